// File: doc/BRIEF.md
# Auto-Baud Detector (Break and Sync Measurement)

This block listens to a serial receive line and learns the sender's bit rate. The sender opens with a long low break. A high delimiter follows, then a byte frame that carries the value 0x55. The block times the break in bit units of the prescaler currently in use. It checks that the delimiter is long enough, then counts clock cycles across the alternating sync pattern. The result is a new prescaler together with a 3-bit modulation value that holds the fractional eighths of a bit. Both are loaded into the baud generator, which is outside this block.

Software sets an enable input and a 2-bit delimiter length. The block reports a recognised break, a break that ran too long, and a sync character that ran past the counter's range. A single-cycle strobe marks each new result. The receive line is expected to be already synchronised to the clock. The sync frame is sent least significant bit first, so the line falls at the start bit and at data bits 1, 3, 5 and 7.

Top module: `abaud_detect`

## Requirements
- R1: After reset, `presc_out`, `mod_out`, `brk_seen`, `brk_timeout`, `sync_timeout` and `result_valid` are all 0.
- R2: A low period on `rx` of at least 11 and at most 22 whole bit times (one bit time is `cur_presc` clocks), ended by a rise, sets `brk_seen` to 1.
- R3: A low period shorter than 11 bit times leaves `brk_seen` at 0 and produces no result.
- R4: A low period that reaches 23 bit times sets `brk_timeout` to 1 and produces no result for the characters that follow it.
- R5: After a break, the high delimiter must last at least `delim_sel`+1 bit times (`delim_sel` 0 to 3 gives 1 to 4 bit times). If the line falls sooner, the attempt is dropped with no result.
- R6: N is the number of clocks from the falling edge of the sync start bit to the falling edge of data bit 7. The block loads `presc_out` = N/8 and `mod_out` = N mod 8, and pulses `result_valid` high for exactly one cycle.
- R7: If the sync measurement counter reaches its all-ones value of 2^(PRESC_W+3)-1 before the fourth falling edge after the start, `sync_timeout` is set to 1 and no result is produced.
- R8: While `enable` is 0, no detection takes place, and `brk_seen`, `brk_timeout` and `sync_timeout` are cleared on the next clock.
- R9: `presc_out` and `mod_out` keep their last values until the next `result_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Detection enable |
| rx | input | 1 | Synchronised receive line, idle high |
| delim_sel | input | 2 | Minimum delimiter length, value+1 bit times |
| cur_presc | input | PRESC_W | Prescaler in effect, used to time break and delimiter |
| presc_out | output | PRESC_W | Measured prescaler |
| mod_out | output | 3 | Measured fractional eighths of a bit |
| brk_seen | output | 1 | Valid break recognised (sticky while enabled) |
| brk_timeout | output | 1 | Break exceeded 22 bit times (sticky while enabled) |
| sync_timeout | output | 1 | Sync field overflowed the counter (sticky while enabled) |
| result_valid | output | 1 | One-cycle strobe when a new result is loaded |

## Verification
The assertions assume that `rx` comes from a synchroniser, that `cur_presc` is at least 2, and that `cur_presc` does not change during a detection. The bench meets these assumptions as follows: it changes `rx` only on falling clock edges, holds each level for a whole number of clocks, and changes `cur_presc` only while the line is idle with detection reset by `enable`. Fractional rates come from lengthening only the sync start bit, so the expected N is an exact count of clocks.

// File: rtl/abaud_pkg.sv
// Shared types and constants for the auto-baud detector.
package abaud_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BREAK,
        ST_DELIM,
        ST_MEASURE,
        ST_WAIT_HIGH
    } abaud_state_t;

    localparam int BIT_CNT_W    = 5;
    localparam int BRK_MIN_BITS = 11;
    localparam int BRK_MAX_BITS = 22;
endpackage

// File: rtl/abaud_bit_timer.sv
// Counts whole bit times of a steady line level, where one bit time is
// `period` clocks. Loading with clr counts the current cycle as the
// first clock. Assumes period >= 2. The bit count saturates at all-ones.
module abaud_bit_timer #(
    parameter int PRESC_W = 16,
    parameter int BITS_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               run,
    input  logic [PRESC_W-1:0] period,
    output logic [BITS_W-1:0]  bits
);
    logic [PRESC_W-1:0] tick;
    logic [PRESC_W:0]   tick_nxt;

    // Next clock count inside the current bit time.
    always_comb tick_nxt = {1'b0, tick} + 1'b1;

    // Advance the clock count and roll whole bit times into bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick <= '0;
            bits <= '0;
        end else if (clr) begin
            tick <= PRESC_W'(1);
            bits <= '0;
        end else if (run) begin
            if (tick_nxt >= {1'b0, period}) begin
                tick <= '0;
                if (bits != '1) bits <= bits + 1'b1;
            end else begin
                tick <= tick_nxt[PRESC_W-1:0];
            end
        end
    end
endmodule

// File: rtl/abaud_sync_meter.sv
// Counts clocks and falling edges across the sync character. clr loads
// the count with 1, for the start-bit edge cycle. The count saturates at
// all-ones, and `full` flags that state.
module abaud_sync_meter #(
    parameter int CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             fall,
    output logic [CNT_W-1:0] cnt,
    output logic [1:0]       edges,
    output logic             full
);
    // Saturation marker for the measurement.
    always_comb full = &cnt;

    // Clock and edge counting while the measurement runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            edges <= '0;
        end else if (clr) begin
            cnt   <= CNT_W'(1);
            edges <= '0;
        end else if (run) begin
            if (!full) cnt <= cnt + 1'b1;
            if (fall)  edges <= edges + 1'b1;
        end
    end
endmodule

// File: rtl/abaud_detect.sv
// Auto-baud detector top. It times a break in units of cur_presc, checks
// the delimiter, then measures 8 bit times of a 0x55 sync character.
// Assumes rx is synchronised to clk and cur_presc >= 2 stays steady
// during a detection.
module abaud_detect
    import abaud_pkg::*;
#(
    parameter int PRESC_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               rx,
    input  logic [1:0]         delim_sel,
    input  logic [PRESC_W-1:0] cur_presc,
    output logic [PRESC_W-1:0] presc_out,
    output logic [2:0]         mod_out,
    output logic               brk_seen,
    output logic               brk_timeout,
    output logic               sync_timeout,
    output logic               result_valid
);
    localparam int CNT_W = PRESC_W + 3;

    abaud_state_t         state;
    logic                 rx_q;
    logic                 fall;
    logic                 rise;
    logic                 tmr_clr;
    logic                 tmr_run;
    logic [BIT_CNT_W-1:0] bits;
    logic [BIT_CNT_W-1:0] delim_need;
    logic                 meas_clr;
    logic                 meas_run;
    logic [CNT_W-1:0]     meas_cnt;
    logic [1:0]           meas_edges;
    logic                 meas_full;
    logic                 delim_ok;

    // Edge detection on the receive line.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= 1'b1;
        else        rx_q <= rx;
    end

    // Edge flags, delimiter target and counter controls.
    always_comb begin
        fall       = rx_q & ~rx;
        rise       = ~rx_q & rx;
        delim_need = BIT_CNT_W'(delim_sel) + 1'b1;
        delim_ok   = bits >= delim_need;
        tmr_clr    = enable && ((state == ST_IDLE && fall) ||
                                (state == ST_BREAK && rx));
        tmr_run    = enable && ((state == ST_BREAK && !rx) ||
                                (state == ST_DELIM && rx));
        meas_clr   = enable && state == ST_DELIM && fall && delim_ok;
        meas_run   = enable && state == ST_MEASURE;
    end

    abaud_bit_timer #(.PRESC_W(PRESC_W), .BITS_W(BIT_CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .run    (tmr_run),
        .period (cur_presc),
        .bits   (bits)
    );

    abaud_sync_meter #(.CNT_W(CNT_W)) u_meter (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (meas_clr),
        .run   (meas_run),
        .fall  (fall),
        .cnt   (meas_cnt),
        .edges (meas_edges),
        .full  (meas_full)
    );

    // Sequencer: break, delimiter and sync phases, with flags and results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            presc_out    <= '0;
            mod_out      <= '0;
            brk_seen     <= 1'b0;
            brk_timeout  <= 1'b0;
            sync_timeout <= 1'b0;
            result_valid <= 1'b0;
        end else if (!enable) begin
            state        <= ST_IDLE;
            brk_seen     <= 1'b0;
            brk_timeout  <= 1'b0;
            sync_timeout <= 1'b0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (fall) state <= ST_BREAK;
                end
                ST_BREAK: begin
                    if (bits > BIT_CNT_W'(BRK_MAX_BITS)) begin
                        brk_timeout <= 1'b1;
                        state       <= ST_WAIT_HIGH;
                    end else if (rx) begin
                        if (bits >= BIT_CNT_W'(BRK_MIN_BITS)) begin
                            brk_seen <= 1'b1;
                            state    <= ST_DELIM;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_DELIM: begin
                    if (fall) state <= delim_ok ? ST_MEASURE : ST_IDLE;
                end
                ST_MEASURE: begin
                    if (fall && meas_edges == 2'd3) begin
                        presc_out    <= meas_cnt[CNT_W-1:3];
                        mod_out      <= meas_cnt[2:0];
                        result_valid <= 1'b1;
                        state        <= ST_IDLE;
                    end else if (meas_full) begin
                        sync_timeout <= 1'b1;
                        state        <= ST_WAIT_HIGH;
                    end
                end
                ST_WAIT_HIGH: begin
                    if (rx) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Rising edge is kept for readability of the edge pair.
    logic unused_rise;
    always_comb unused_rise = rise;
endmodule

// File: rtl/abaud_detect_chk.sv
// Property checker for the auto-baud detector, bound to every instance.
// Assumes a synchronous active-low reset asserted from time zero.
module abaud_detect_chk #(
    parameter int PRESC_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               enable,
    input logic [PRESC_W-1:0] presc_out,
    input logic [2:0]         mod_out,
    input logic               brk_seen,
    input logic               brk_timeout,
    input logic               sync_timeout,
    input logic               result_valid
);
    // R6
    valid_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R8
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!result_valid && !brk_seen && !brk_timeout && !sync_timeout));

    // R7
    sync_timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && sync_timeout) |=> sync_timeout);

    // R4
    timeout_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_timeout) |-> !result_valid);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(presc_out) && $stable(mod_out)) |-> result_valid);
endmodule

bind abaud_detect abaud_detect_chk #(.PRESC_W(PRESC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .presc_out    (presc_out),
    .mod_out      (mod_out),
    .brk_seen     (brk_seen),
    .brk_timeout  (brk_timeout),
    .sync_timeout (sync_timeout),
    .result_valid (result_valid)
);

// File: tb/abaud_detect_test.sv
module abaud_detect_test;
    localparam int PW = 8;

    typedef struct packed {
        int cur; int brk; int dsel; int dlen; int p2; int ext;
        int exp_brk; int exp_valid; int exp_to;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8,  13, 0, 1, 8,  0, 1, 1, 0},
        '{10, 11, 1, 2, 12, 3, 1, 1, 0},
        '{6,  22, 3, 4, 20, 7, 1, 1, 0},
        '{8,  10, 0, 1, 8,  0, 0, 0, 0},
        '{8,  23, 0, 1, 8,  0, 0, 0, 1},
        '{8,  12, 2, 2, 8,  0, 1, 0, 0},
        '{8,  12, 2, 6, 5,  2, 1, 1, 0},
        '{16, 30, 0, 1, 8,  0, 0, 0, 1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          rx = 1'b1;
    logic [1:0]    delim_sel = 2'd0;
    logic [PW-1:0] cur_presc = PW'(8);
    logic [PW-1:0] presc_out;
    logic [2:0]    mod_out;
    logic          brk_seen, brk_timeout, sync_timeout, result_valid;

    int errors = 0;
    int checks = 0;
    int nvalid = 0;
    int got_p = 0;
    int got_m = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    abaud_detect #(.PRESC_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .rx(rx),
        .delim_sel(delim_sel), .cur_presc(cur_presc),
        .presc_out(presc_out), .mod_out(mod_out), .brk_seen(brk_seen),
        .brk_timeout(brk_timeout), .sync_timeout(sync_timeout),
        .result_valid(result_valid)
    );

    // Capture each result strobe away from the active edge.
    always @(negedge clk) begin
        if (rst_n && result_valid) begin
            nvalid++;
            got_p = int'(presc_out);
            got_m = int'(mod_out);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hold(input logic lvl, input int n);
        rx = lvl;
        repeat (n) @(negedge clk);
    endtask

    task automatic rearm();
        enable = 1'b0;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        nvalid = 0;
    endtask

    task automatic send_seq(input vec_t v);
        hold(1'b1, 5);
        hold(1'b0, v.brk * v.cur);
        hold(1'b1, v.dlen * v.cur);
        hold(1'b0, v.p2 + v.ext);
        for (int i = 0; i < 8; i++) hold(((i % 2) == 0), v.p2);
        hold(1'b1, v.p2 + 10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 presc_out", int'(presc_out), 0);
        check("R1 mod_out", int'(mod_out), 0);
        check("R1 flags", int'({brk_seen, brk_timeout, sync_timeout, result_valid}), 0);

        // Table walk: R2, R3, R4, R5, R6, R9
        for (int k = 0; k < 8; k++) begin
            int prev_p;
            int prev_m;
            cur_presc = PW'(VECS[k].cur);
            delim_sel = 2'(VECS[k].dsel);
            rearm();
            prev_p = int'(presc_out);
            prev_m = int'(mod_out);
            send_seq(VECS[k]);
            check($sformatf("R2 R3 brk_seen vec%0d", k), int'(brk_seen), VECS[k].exp_brk);
            check($sformatf("R4 brk_timeout vec%0d", k), int'(brk_timeout), VECS[k].exp_to);
            check($sformatf("R5 R6 result count vec%0d", k), nvalid, VECS[k].exp_valid);
            if (VECS[k].exp_valid != 0) begin
                check($sformatf("R6 presc vec%0d", k), got_p, (8 * VECS[k].p2 + VECS[k].ext) / 8);
                check($sformatf("R6 mod vec%0d", k), got_m, (8 * VECS[k].p2 + VECS[k].ext) % 8);
            end else begin
                check($sformatf("R9 presc held vec%0d", k), int'(presc_out), prev_p);
                check($sformatf("R9 mod held vec%0d", k), int'(mod_out), prev_m);
            end
        end

        // R7: sync start held low past the 11-bit counter range (2047)
        cur_presc = PW'(8);
        delim_sel = 2'd0;
        rearm();
        hold(1'b1, 5);
        hold(1'b0, 13 * 8);
        hold(1'b1, 8);
        hold(1'b0, 2100);
        check("R7 sync_timeout", int'(sync_timeout), 1);
        check("R7 no result", nvalid, 0);
        hold(1'b1, 10);
        check("R7 flag sticky", int'(sync_timeout), 1);

        // R8: enable low blocks detection and clears flags
        enable = 1'b0;
        nvalid = 0;
        @(negedge clk);
        check("R8 flags cleared", int'({brk_seen, brk_timeout, sync_timeout}), 0);
        send_seq(VECS[0]);
        check("R8 no brk_seen", int'(brk_seen), 0);
        check("R8 no result", nvalid, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule